// File: doc/BRIEF.md
# Continuous 0110 Sequence Lock

This block is the controller of a two-key lock. Each clock cycle it may receive one key event, given as a strobe together with the key value (0 or 1). There is no start key: the controller watches the key stream continuously and raises its unlock output whenever the four most recent key events were 0, then 1, then 1, then 0. A match may share keys with the next one, so the stream 0,1,1,0,1,1,0 opens the lock twice.

The controller is a Moore machine with five states. Each state records how far along the combination the key stream currently is: nothing matched, "0", "01", "011", or the whole combination. These five states are held in a 3-bit register, which leaves three codes unused. In silicon the register may power up holding any code, so the synchronous reset exists only for simulation. The next key event takes every unused code to a defined state. A parameter chooses the code that reset loads, so a testbench can start the machine in an unused code.

Top module: `seqlock_top`

## Requirements
- R1: With the default reset code, the cycle after a reset edge shows the nothing-matched state and unlock_o is 0.
- R2: After a clock edge that samples press_i=1, unlock_o is 1 exactly when the four most recent sampled key values were 0,1,1,0, oldest first. Here bit_i=0 encodes key 0 and bit_i=1 encodes key 1.
- R3: A cycle with press_i=0 does not change the state, whatever bit_i holds, so unlock_o keeps its value.
- R4: Matches may overlap. From the full-match state, a key 1 leads to the "01" state and a key 0 leads to the "0" state, so 0,1,1,0,1,1,0 raises unlock_o after the fourth key and again after the seventh.
- R5: unlock_o depends on the current state only, and it can rise only after an edge that sampled a key 0.
- R6: From any unused code (5, 6 or 7), a key 0 leads to the "0" state and a key 1 leads to the nothing-matched state. After any key event the state code is one of the five used codes.
- R7: While the machine holds an unused code and no key arrives, unlock_o stays 0 and the code is kept.
- R8: From "011", a key 1 returns to nothing-matched. From "0", a key 0 stays in "0". From "01", a key 0 leads to "0".

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, used in simulation only; loads RST_CODE |
| press_i | input | 1 | Key event strobe, one event per cycle at most |
| bit_i | input | 1 | Key value, sampled when press_i is 1 |
| unlock_o | output | 1 | High while the last four keys were 0,1,1,0 |

## Verification
The hardest situation to reach is recovery from an unused state code. The ports offer no way to load a code, and an arbitrary power-up value cannot be produced on purpose. The bench therefore builds three extra instances whose reset code parameter is 5, 6 or 7. It drives all four instances with the same key stream and compares each of them on every cycle with one history-based model. That model is valid for every starting code, because the first key out of an unused code behaves exactly like a first key after a clean start. The bench first holds the machine idle in the unused code, and then leaves it by the 0 path and by the 1 path.

// File: rtl/seqlock_pkg.sv
package seqlock_pkg;

    localparam int STATE_W = 3;

    typedef enum logic [STATE_W-1:0] {
        ST_NONE = 3'd0,
        ST_Z    = 3'd1,
        ST_ZO   = 3'd2,
        ST_ZOO  = 3'd3,
        ST_FULL = 3'd4
    } lock_state_t;

    typedef struct packed {
        lock_state_t state;
    } lock_regs_t;

endpackage

// File: rtl/seqlock_step.sv
module seqlock_step
    import seqlock_pkg::*;
(
    input  lock_state_t cur_i,
    input  logic        key_i,
    output lock_state_t nxt_o
);
    always_comb begin
        case (cur_i)
            ST_NONE: nxt_o = key_i ? ST_NONE : ST_Z;
            ST_Z:    nxt_o = key_i ? ST_ZO   : ST_Z;
            ST_ZO:   nxt_o = key_i ? ST_ZOO  : ST_Z;
            ST_ZOO:  nxt_o = key_i ? ST_NONE : ST_FULL;
            ST_FULL: nxt_o = key_i ? ST_ZO   : ST_Z;
            // unused codes: a 0 counts as a first match, a 1 clears
            default: nxt_o = key_i ? ST_NONE : ST_Z;
        endcase
    end
endmodule

// File: rtl/seqlock_decode.sv
module seqlock_decode
    import seqlock_pkg::*;
(
    input  lock_state_t cur_i,
    output logic        open_o
);
    always_comb begin
        open_o = (cur_i == ST_FULL);
    end
endmodule

// File: rtl/seqlock_top.sv
module seqlock_top
    import seqlock_pkg::*;
#(
    parameter logic [STATE_W-1:0] RST_CODE = 3'd0
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic press_i,
    input  logic bit_i,
    output logic unlock_o
);
    lock_regs_t             r_d, r_q;
    lock_state_t            step_nxt;
    logic [STATE_W-1:0]     state_q;

    seqlock_step u_step (
        .cur_i (r_q.state),
        .key_i (bit_i),
        .nxt_o (step_nxt)
    );

    seqlock_decode u_dec (
        .cur_i  (r_q.state),
        .open_o (unlock_o)
    );

    always_comb begin
        r_d = r_q;
        if (press_i) begin
            r_d.state = step_nxt;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            r_q.state <= lock_state_t'(RST_CODE);
        end else begin
            r_q <= r_d;
        end
    end

    assign state_q = r_q.state;

endmodule

// File: rtl/seqlock_chk.sv
module seqlock_chk (
    input logic       clk_i,
    input logic       rst_i,
    input logic       press_i,
    input logic       bit_i,
    input logic [2:0] state_q,
    input logic       unlock_o
);
    // R3: no key event, no state change
    assert_hold_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        !press_i |=> $stable(state_q));

    // R5: unlock rises only after a sampled key 0
    assert_rise_after_zero_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(unlock_o) |-> $past(press_i && !bit_i));

    // R4: overlap, key 1 from a full match goes to the "01" code
    assert_overlap_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (unlock_o && press_i && bit_i) |=> (state_q == 3'd2 && !unlock_o));

    // R6: recovery from unused codes
    assert_recover_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (press_i && state_q > 3'd4) |=> (state_q == ($past(bit_i) ? 3'd0 : 3'd1)));

    // R6: any key event leaves a used code
    assert_legal_after_key_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        press_i |=> (state_q <= 3'd4));

    // R7: unused code keeps unlock low
    assert_unused_low_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q > 3'd4) |-> !unlock_o);
endmodule

bind seqlock_top seqlock_chk u_chk (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .press_i  (press_i),
    .bit_i    (bit_i),
    .state_q  (state_q),
    .unlock_o (unlock_o)
);

// File: tb/seqlock_top_tb.sv
module seqlock_top_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic press = 1'b0;
    logic kbit = 1'b0;
    logic u_main, u5, u6, u7;

    int vectors = 0;
    int fails = 0;
    int hist = 0;
    int cnt = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    seqlock_top #(.RST_CODE(3'd0)) u_dut (
        .clk_i(clk), .rst_i(rst), .press_i(press), .bit_i(kbit), .unlock_o(u_main));
    seqlock_top #(.RST_CODE(3'd5)) u_dut5 (
        .clk_i(clk), .rst_i(rst), .press_i(press), .bit_i(kbit), .unlock_o(u5));
    seqlock_top #(.RST_CODE(3'd6)) u_dut6 (
        .clk_i(clk), .rst_i(rst), .press_i(press), .bit_i(kbit), .unlock_o(u6));
    seqlock_top #(.RST_CODE(3'd7)) u_dut7 (
        .clk_i(clk), .rst_i(rst), .press_i(press), .bit_i(kbit), .unlock_o(u7));

    function automatic logic expected();
        return (cnt >= 4) && ((hist & 15) == 6);
    endfunction

    task automatic check_one(string who, logic act);
        logic exp;
        exp = expected();
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: unlock act=%b exp=%b", cur_req, who, act, exp);
        end
    endtask

    task automatic compare_all();
        check_one("code0", u_main);
        check_one("code5", u5);
        check_one("code6", u6);
        check_one("code7", u7);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        press = 1'b0;
        @(posedge clk);
        @(posedge clk);
        hist = 0;
        cnt = 0;
        @(negedge clk);
        rst = 1'b0;
        compare_all();
    endtask

    task automatic step(logic p, logic b);
        press = p;
        kbit = b;
        @(posedge clk);
        if (p) begin
            hist = ((hist << 1) | int'(b)) & 15;
            cnt++;
        end
        @(negedge clk);
        compare_all();
    endtask

    task automatic keys(logic [15:0] seq, int n);
        for (int i = n - 1; i >= 0; i--) step(1'b1, seq[i]);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: act=timeout exp=completion");
        summary();
    end

    initial begin
        int lfsr;
        // R1: reset state
        cur_req = "R1";
        do_reset();
        // R2: plain combination
        cur_req = "R2";
        keys(16'b0110, 4);
        keys(16'b1000, 4);
        // R3: idle cycles with changing bit_i
        cur_req = "R3";
        keys(16'b011, 3);
        step(1'b0, 1'b1);
        step(1'b0, 1'b0);
        step(1'b1, 1'b0);
        step(1'b0, 1'b1);
        step(1'b0, 1'b0);
        // R4: overlapping matches
        cur_req = "R4";
        keys(16'b0110110, 7);
        keys(16'b0110, 4);
        // R8: partial-match edges
        cur_req = "R8";
        keys(16'b00110, 5);
        keys(16'b01110110, 8);
        keys(16'b0100110, 7);
        // R7: hold in reset code with no keys
        cur_req = "R7";
        do_reset();
        for (int i = 0; i < 5; i++) step(1'b0, i[0]);
        // R6: leave unused codes by key 0
        cur_req = "R6";
        keys(16'b0110, 4);
        // R6: leave unused codes by key 1
        do_reset();
        keys(16'b1110, 4);
        keys(16'b110, 3);
        // R5 and R2: long pseudo-random stream
        cur_req = "R5";
        do_reset();
        lfsr = 16'hACE1;
        for (int i = 0; i < 600; i++) begin
            lfsr = ((lfsr >> 1) | ((((lfsr >> 0) ^ (lfsr >> 2) ^ (lfsr >> 3) ^ (lfsr >> 5)) & 1) << 15)) & 16'hFFFF;
            step((lfsr & 3) != 0, lfsr[4]);
        end
        summary();
    end
endmodule